// File: doc/BRIEF.md
# Interrupt Vector Receive Unit

This block holds the software-posted interrupt vectors of one processor thread. Each posting write names a vector number and sets the matching bit of a pending bitmap. The full bitmap stays visible on an output port. Observing it has no side effect.

A separate "take" strobe services the vectors. The take output always shows the number of the highest-numbered pending vector. When the strobe is asserted, that vector's pending bit is cleared at the clock edge. A handler that takes once per trap therefore drains the pending vectors from the highest number to the lowest.

A level interrupt request goes to the core whenever the thread's interrupt enable is set and at least one vector is pending. Vectors that are posted while the enable is low collect in the bitmap and cause no request.

Top module: `ivr_unit`

## Requirements
- R1: When `post_valid` is high at a clock edge, bit `post_vec` of `pend_bitmap` is 1 after that edge. No pending bit is ever set without a post.
- R2: `irq` is 1 exactly when `int_en` is 1 and `pend_bitmap` is nonzero. While `int_en` is 0, `irq` stays 0 even with vectors pending.
- R3: `take_vec` shows the highest index of any set bit of `pend_bitmap`. A higher vector number has higher priority.
- R4: When `take_rd` is high at an edge, the bit named by `take_vec` is cleared at that edge. Repeated takes return the pending vectors in descending order.
- R5: Observing `pend_bitmap` changes nothing. A vector stays visible in the bitmap until a take clears it, whatever the state of `int_en`.
- R6: `irq` falls right after the edge at which the last pending bit is cleared.
- R7: If a post and a take name the same bit at the same edge, the bit stays set.
- R8: A take while nothing is pending shows `take_vec` = 0 and changes no state.
- R9: Posting a vector that is already pending has no further effect. A single take clears it.
- R10: An active-low `rst_n` clears every pending bit, so `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| post_valid | input | 1 | Posting write strobe |
| post_vec | input | VEC_W | Vector number being posted |
| take_rd | input | 1 | Take strobe; clears the vector shown on take_vec |
| int_en | input | 1 | Thread interrupt enable |
| take_vec | output | VEC_W | Highest pending vector number (0 when empty) |
| pend_bitmap | output | NUM_VEC | Pending bitmap |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default of 64 vectors, so `take_vec` is 6 bits wide. This width lets the stimulus post vector 0 and vector 63, the two ends of the priority scan. It also lets the stimulus hit the top bit with a post and a take at the same edge, and re-post a vector that is still pending. The vectors 5, 1 and 7 are posted with the enable low. The bench then checks that they drain in the order 7, 5, 1 once the enable is set.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  typedef struct packed {
    logic setEn;
    logic clrEn;
  } ivr_strobe_t;
endpackage

// File: rtl/ivr_ctrl.sv
module ivr_ctrl
  import ivr_pkg::*;
(
  input  logic        postValid,
  input  logic        takeRd,
  input  logic        anyPend,
  input  logic        intEn,
  output ivr_strobe_t strb,
  output logic        irqReq
);
  // Clearing needs something pending; an empty take is a no-op (R8)
  always_comb begin
    strb.setEn = postValid;
    strb.clrEn = takeRd & anyPend;
    irqReq     = intEn & anyPend;
  end
endmodule

// File: rtl/ivr_datapath.sv
module ivr_datapath
  import ivr_pkg::*;
#(
  parameter int NUM_VEC = 64,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ivr_strobe_t        strb,
  input  logic [VEC_W-1:0]   setIdx,
  output logic [VEC_W-1:0]   topIdx,
  output logic [NUM_VEC-1:0] pend,
  output logic               anyPend
);
  logic [NUM_VEC-1:0] setMask;
  logic [NUM_VEC-1:0] clrMask;

  // Priority scan: the last hit wins, so the highest index is kept (R3)
  always_comb begin
    topIdx = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (pend[i]) topIdx = VEC_W'(i);
    end
  end

  assign anyPend = |pend;

  // One flop per vector; the set term is ORed in after the clear term (R7)
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_bit
    assign setMask[g] = strb.setEn && (setIdx == VEC_W'(g));
    assign clrMask[g] = strb.clrEn && (topIdx == VEC_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pend[g] <= 1'b0;
      else       pend[g] <= (pend[g] & ~clrMask[g]) | setMask[g];
    end
  end

  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> pend[$past(setIdx)]);
  p_no_spurious_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.setEn |=> (pend & ~$past(pend)) == '0);
  p_take_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrEn && !(strb.setEn && setIdx == topIdx)) |=> !pend[$past(topIdx)]);
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrEn && strb.setEn && setIdx == topIdx) |=> pend[$past(topIdx)]);
  p_top_is_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> pend[topIdx]);
endmodule

// File: rtl/ivr_unit.sv
module ivr_unit
  import ivr_pkg::*;
#(
  parameter int NUM_VEC = 64,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               post_valid,
  input  logic [VEC_W-1:0]   post_vec,
  input  logic               take_rd,
  input  logic               int_en,
  output logic [VEC_W-1:0]   take_vec,
  output logic [NUM_VEC-1:0] pend_bitmap,
  output logic               irq
);
  ivr_strobe_t strb;
  logic        anyPend;

  ivr_ctrl u_ctrl (
    .postValid(post_valid),
    .takeRd   (take_rd),
    .anyPend  (anyPend),
    .intEn    (int_en),
    .strb     (strb),
    .irqReq   (irq)
  );

  ivr_datapath #(.NUM_VEC(NUM_VEC)) u_dp (
    .clk    (clk),
    .rstN   (rst_n),
    .strb   (strb),
    .setIdx (post_vec),
    .topIdx (take_vec),
    .pend   (pend_bitmap),
    .anyPend(anyPend)
  );

  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);
  p_irq_falls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && $past(int_en) && $fell(|pend_bitmap)) |-> !irq);
  p_empty_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_rd && !post_valid && pend_bitmap == '0) |=> pend_bitmap == '0);
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_rd && !post_valid) |=> $stable(pend_bitmap));
endmodule

// File: tb/ivr_unit_tb_top.sv
module ivr_unit_tb_top;
  localparam int W = 6;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic postValid = 1'b0;
  logic [W-1:0] postVec = '0;
  logic takeRd = 1'b0;
  logic intEn = 1'b0;
  logic [W-1:0] takeVec;
  logic [N-1:0] bitmap;
  logic irq;
  int   nRun = 0;
  int   nFail = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  ivr_unit #(.NUM_VEC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .post_valid(postValid), .post_vec(postVec),
    .take_rd(takeRd), .int_en(intEn), .take_vec(takeVec),
    .pend_bitmap(bitmap), .irq(irq)
  );

  typedef struct packed {
    logic         post;
    logic [W-1:0] vec;
    logic         take;
    logic         en;
    logic [W-1:0] expVec;
    logic [N-1:0] expBm;
    logic         expIrq;
  } step_t;

  localparam int NSTEP = 16;
  localparam step_t STEPS [NSTEP] = '{
    '{1'b1, 6'd5,  1'b0, 1'b0, 6'd0,  64'h20, 1'b0},                 // R1 R2
    '{1'b1, 6'd1,  1'b0, 1'b0, 6'd5,  64'h22, 1'b0},                 // R1 R3
    '{1'b1, 6'd7,  1'b0, 1'b0, 6'd5,  64'hA2, 1'b0},                 // R2 R5
    '{1'b0, 6'd0,  1'b0, 1'b1, 6'd7,  64'hA2, 1'b1},                 // R2 R3 R5
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd7,  64'h22, 1'b1},                 // R4
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd5,  64'h02, 1'b1},                 // R4
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd1,  64'h00, 1'b0},                 // R4 R6
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd0,  64'h00, 1'b0},                 // R8
    '{1'b1, 6'd63, 1'b0, 1'b1, 6'd0,  64'h8000_0000_0000_0000, 1'b1}, // R1
    '{1'b1, 6'd63, 1'b1, 1'b1, 6'd63, 64'h8000_0000_0000_0000, 1'b1}, // R7
    '{1'b1, 6'd0,  1'b0, 1'b1, 6'd63, 64'h8000_0000_0000_0001, 1'b1}, // R1
    '{1'b1, 6'd63, 1'b0, 1'b1, 6'd63, 64'h8000_0000_0000_0001, 1'b1}, // R9
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd63, 64'h1, 1'b1},                  // R9 R4
    '{1'b0, 6'd0,  1'b1, 1'b1, 6'd0,  64'h0, 1'b0},                  // R6
    '{1'b1, 6'd40, 1'b0, 1'b0, 6'd0,  64'h100_0000_0000, 1'b0},      // R2
    '{1'b0, 6'd0,  1'b1, 1'b0, 6'd40, 64'h0, 1'b0}                   // R4
  };

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset bitmap", bitmap, '0);
    check("R10 reset irq", N'(irq), '0);
    rst_n = 1'b1;
    for (int s = 0; s < NSTEP; s++) begin
      @(negedge clk);
      postValid = STEPS[s].post;
      postVec   = STEPS[s].vec;
      takeRd    = STEPS[s].take;
      intEn     = STEPS[s].en;
      #1;
      check($sformatf("R3 take_vec step %0d", s), N'(takeVec), N'(STEPS[s].expVec));
      @(posedge clk);
      #1;
      check($sformatf("R1/R4/R7/R9 bitmap step %0d", s), bitmap, STEPS[s].expBm);
      check($sformatf("R2/R6 irq step %0d", s), N'(irq), N'(STEPS[s].expIrq));
    end
    // R5: idle cycles leave a pending vector visible
    @(negedge clk);
    postValid = 1'b1; postVec = 6'd12; takeRd = 1'b0; intEn = 1'b0;
    @(negedge clk);
    postValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R5 bitmap held", bitmap, 64'h1000);
    check("R5 take_vec", N'(takeVec), N'(12));
    // R10: reset mid-run clears pending
    intEn = 1'b1;
    #1;
    check("R2 irq with pending", N'(irq), N'(1));
    rst_n = 1'b0;
    #1;
    check("R10 bitmap cleared", bitmap, '0);
    check("R10 irq low", N'(irq), '0);
    @(negedge clk);
    rst_n = 1'b1;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule